// File: doc/BRIEF.md
# Digitizer Acquisition Window Controller

This block decides when a multi-channel sampling digitizer stores samples in its acquisition memory. External start and stop pulses each pass through a programmable delay. The delayed events open and close an acquisition window. While the window is open, every enabled sample-clock cycle produces one memory write at an address that the block generates.

There are two operating styles. In triggered mode the window opens on a delayed start. It closes on a delayed stop, or when a coded number of samples has been written, whichever happens first. In continuous mode the window opens by itself after reset and closes only on a delayed stop. When the window closes, a single-cycle done pulse reports the address of the final write.

There is no data stream at the edge of this block. All pins are plain control and status levels or pulses, so no back-pressure applies. A downstream reader must capture `done` and `last_addr` in the cycle they are presented.

Top module: `acq_window_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `active`=0, `done`=0 and `wr_addr`=0, and discards any start or stop that is still counting down its delay.
- R2: A start pulse sampled at edge E0 makes `active` rise at edge E0+`cfg_start_dly`+2, and not earlier.
- R3: A stop pulse sampled at edge S0 while the window is open makes `active` fall at edge S0+`cfg_stop_dly`+2. A write takes place at that edge when `smp_en` was high.
- R4: In triggered mode (`cfg_free_run`=0, `cfg_wrap`=0), the window closes at the edge that performs the write to address page_size-1.
- R5: `cfg_size` selects page_size as follows: 0=131072, 1=16384, 2=4096, 3=2048, 4=1024, 5=512, 6=256, 7=128.
- R6: In continuous mode (`cfg_free_run`=1), the window opens at the first edge after reset is released. No sample count closes it; only a delayed stop does. After that stop the window stays closed until a delayed start reopens it.
- R7: When `cfg_wrap`=1, or in continuous mode, the address rolls from page_size-1 back to 0 and the window stays open.
- R8: `wr_en` equals `active` AND `smp_en`. `wr_addr` is 0 in the first cycle of a window and advances by one only on edges where `wr_en` was high.
- R9: A delayed start that arrives while the window is open has no effect on `wr_addr`. A delayed stop that arrives while the window is closed produces no `done`.
- R10: `done` is high for exactly one cycle after the window closes. `last_addr` then holds the address of the final write of that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample clock enable; one write per enabled cycle while active |
| start_i | input | 1 | External start pulse |
| stop_i | input | 1 | External stop pulse |
| cfg_start_dly | input | DLY_W | Extra clocks of delay applied to start |
| cfg_stop_dly | input | DLY_W | Extra clocks of delay applied to stop |
| cfg_free_run | input | 1 | 1 = continuous mode, 0 = triggered mode |
| cfg_wrap | input | 1 | 1 = address rolls over at page end instead of closing |
| cfg_size | input | 3 | Page size code (see R5) |
| active | output | 1 | Acquisition window open |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| done | output | 1 | One-cycle pulse when the window closes |
| last_addr | output | ADDR_W | Address of the final write of the last window |

## Verification
The assertions assume that the configuration inputs stay unchanged while a window is open and while a delay is counting down. They also assume that start and stop are single-cycle pulses, and that a second pulse on the same input does not arrive before the first has finished its delay. The stimulus changes configuration only while the block is idle or held in reset. It drives each trigger for one cycle and leaves a gap longer than the programmed delay before the next pulse. Under those conditions, the mode-change and window-close properties in the checker describe the complete behaviour.

// File: rtl/acq_pkg.sv
package acq_pkg;

  localparam int MAX_ADDR_W = 17;

  typedef enum logic [2:0] {
    SZ_128K = 3'd0,
    SZ_16K  = 3'd1,
    SZ_4K   = 3'd2,
    SZ_2K   = 3'd3,
    SZ_1K   = 3'd4,
    SZ_512  = 3'd5,
    SZ_256  = 3'd6,
    SZ_128  = 3'd7
  } size_code_e;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_RUN  = 1'b1
  } win_state_e;

  // log2 of the page size selected by a code
  function automatic int size_log2(input logic [2:0] code);
    int sh;
    case (code)
      3'd0:    sh = 17;
      3'd1:    sh = 14;
      default: sh = 14 - int'(code);
    endcase
    return sh;
  endfunction

  // highest address inside the page
  function automatic logic [MAX_ADDR_W-1:0] page_last(input logic [2:0] code);
    logic [MAX_ADDR_W:0] span;
    span = (MAX_ADDR_W+1)'(1) << size_log2(code);
    return MAX_ADDR_W'(span - 1'b1);
  endfunction

endpackage

// File: rtl/acq_trig_delay.sv
module acq_trig_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);

  logic             busy_q;
  logic [DLY_W-1:0] cnt_q;
  logic             fire_q;

  // one pending slot: load on trigger, count down, then emit one pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) begin
          fire_q <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (trig_i) begin
        busy_q <= 1'b1;
        cnt_q  <= dly_i;
      end
    end
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/acq_addr_gen.sv
module acq_addr_gen #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic [ADDR_W-1:0] last_idx,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  logic [ADDR_W-1:0] addr_q;

  assign at_last = (addr_q == last_idx);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      addr_q <= '0;
    end else if (step) begin
      addr_q <= at_last ? '0 : addr_q + 1'b1;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/acq_window_ctrl.sv
module acq_window_ctrl
  import acq_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int ADDR_W = MAX_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_en,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DLY_W-1:0]  cfg_start_dly,
  input  logic [DLY_W-1:0]  cfg_stop_dly,
  input  logic              cfg_free_run,
  input  logic              cfg_wrap,
  input  logic [2:0]        cfg_size,
  output logic              active,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              done,
  output logic [ADDR_W-1:0] last_addr
);

  localparam int N_TRIG = 2;

  logic [N_TRIG-1:0]       trig_in;
  logic [N_TRIG-1:0]       trig_fire;
  logic [DLY_W-1:0]        trig_dly [N_TRIG];

  assign trig_in[0]  = start_i;
  assign trig_in[1]  = stop_i;
  assign trig_dly[0] = cfg_start_dly;
  assign trig_dly[1] = cfg_stop_dly;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_dly
    acq_trig_delay #(.DLY_W(DLY_W)) dly_i (
      .clk    (clk),
      .rst    (rst),
      .trig_i (trig_in[g]),
      .dly_i  (trig_dly[g]),
      .fire_o (trig_fire[g])
    );
  end

  logic start_fire, stop_fire;
  assign start_fire = trig_fire[0];
  assign stop_fire  = trig_fire[1];

  win_state_e        state_q;
  logic              held_q;
  logic              done_q;
  logic [ADDR_W-1:0] last_q;
  logic [ADDR_W-1:0] prev_q;
  logic [ADDR_W-1:0] addr;
  logic              at_last;
  logic [ADDR_W-1:0] last_idx;
  logic              running, go, limit_end, end_run;

  assign last_idx  = ADDR_W'(page_last(cfg_size));
  assign running   = (state_q == WIN_RUN);
  assign wr_en     = running && smp_en;
  assign limit_end = wr_en && at_last && !cfg_free_run && !cfg_wrap;
  assign end_run   = running && (stop_fire || limit_end);
  assign go        = !running && (start_fire || (cfg_free_run && !held_q));

  acq_addr_gen #(.ADDR_W(ADDR_W)) addr_i (
    .clk      (clk),
    .rst      (rst),
    .clear    (go),
    .step     (wr_en),
    .last_idx (last_idx),
    .addr     (addr),
    .at_last  (at_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WIN_IDLE;
      held_q  <= 1'b0;
      done_q  <= 1'b0;
      last_q  <= '0;
      prev_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!running) begin
        if (go) begin
          state_q <= WIN_RUN;
          held_q  <= 1'b0;
          prev_q  <= '0;
        end
      end else begin
        if (wr_en) prev_q <= addr;
        if (end_run) begin
          state_q <= WIN_IDLE;
          held_q  <= 1'b1;
          done_q  <= 1'b1;
          last_q  <= wr_en ? addr : prev_q;
        end
      end
    end
  end

  assign active    = running;
  assign wr_addr   = addr;
  assign done      = done_q;
  assign last_addr = last_q;

endmodule

// File: rtl/acq_window_chk.sv
module acq_window_chk
  import acq_pkg::*;
#(
  parameter int ADDR_W = MAX_ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_free_run,
  input logic              cfg_wrap,
  input logic [2:0]        cfg_size,
  input logic              start_fire,
  input logic              stop_fire,
  input logic              active,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done
);

  logic [ADDR_W-1:0] top_idx;
  assign top_idx = ADDR_W'(page_last(cfg_size));

  // R2: a delayed start opens an idle window on the next edge
  a_r2_start_opens: assert property (@(posedge clk) disable iff (rst)
    (start_fire && !active) |=> active);

  // R3: a delayed stop closes an open window with a done pulse
  a_r3_stop_closes: assert property (@(posedge clk) disable iff (rst)
    (stop_fire && active) |=> (!active && done));

  // R4: reaching the page end in triggered mode closes the window
  a_r4_limit_closes: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == top_idx && !cfg_free_run && !cfg_wrap) |=> (!active && done));

  // R7: rolling over keeps the window open and restarts the address
  a_r7_rollover: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == top_idx && (cfg_free_run || cfg_wrap) && !stop_fire) |=> (active && wr_addr == '0));

  // R8: no write strobe outside the window
  a_r8_strobe_in_window: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> active);

  // R8: address holds when no write occurred inside a window
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$past(wr_en)) |-> $stable(wr_addr));

  // R8: a window begins at address zero
  a_r8_open_at_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> (wr_addr == '0));

  // R10: done only as a window closes, and lasts one cycle
  a_r10_done_on_close: assert property (@(posedge clk) disable iff (rst)
    done |-> (!active && $past(active)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind acq_window_ctrl acq_window_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cfg_free_run (cfg_free_run),
  .cfg_wrap     (cfg_wrap),
  .cfg_size     (cfg_size),
  .start_fire   (start_fire),
  .stop_fire    (stop_fire),
  .active       (active),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .done         (done)
);

// File: tb/acq_window_ctrl_tb_top.sv
module acq_window_ctrl_tb_top;

  localparam int DLY_W  = 8;
  localparam int ADDR_W = 17;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_en = 1'b1;
  logic              start_i = 1'b0;
  logic              stop_i = 1'b0;
  logic [DLY_W-1:0]  cfg_start_dly = '0;
  logic [DLY_W-1:0]  cfg_stop_dly = '0;
  logic              cfg_free_run = 1'b0;
  logic              cfg_wrap = 1'b0;
  logic [2:0]        cfg_size = 3'd7;
  logic              active, wr_en, done;
  logic [ADDR_W-1:0] wr_addr, last_addr;

  always #5 clk = ~clk;

  acq_window_ctrl #(.DLY_W(DLY_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .smp_en(smp_en), .start_i(start_i), .stop_i(stop_i),
    .cfg_start_dly(cfg_start_dly), .cfg_stop_dly(cfg_stop_dly),
    .cfg_free_run(cfg_free_run), .cfg_wrap(cfg_wrap), .cfg_size(cfg_size),
    .active(active), .wr_en(wr_en), .wr_addr(wr_addr), .done(done),
    .last_addr(last_addr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int elapsed = 0;
  int exp_q[$];
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    elapsed += n;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; tick(1); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1; tick(1); stop_i = 1'b0;
  endtask

  // driver side of the scoreboard: expected final address of a window
  task automatic expect_done(input int a);
    exp_q.push_back(a);
  endtask

  // start a window with delay d and confirm the exact opening edge (R2)
  task automatic open_window(input int d);
    cfg_start_dly = DLY_W'(d);
    pulse_start();
    tick(d + 1);
    check(active == 1'b0, "R2 early", int'(active), 0);
    tick(1);
    check(active == 1'b1, "R2 open", int'(active), 1);
    check(wr_addr == '0, "R8 first addr", int'(wr_addr), 0);
    elapsed = 0;
  endtask

  // monitor: pop and compare on every done pulse
  always @(negedge clk) begin
    if (!rst && done && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9/R10 unexpected done", int'(last_addr), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(last_addr) == e, "R10 last_addr", int'(last_addr), e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check(active == 1'b0, "R1 active", int'(active), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(wr_addr == '0, "R1 wr_addr", int'(wr_addr), 0);

    // triggered mode, page 128 (code 7), restart ignored, enable gaps
    cfg_size = 3'd7;
    open_window(3);
    tick(20);
    check(int'(wr_addr) == 20, "R8 advance", int'(wr_addr), 20);
    pulse_start();
    tick(9);
    check(int'(wr_addr) == 30, "R9 start ignored", int'(wr_addr), 30);
    smp_en = 1'b0;
    tick(5);
    check(int'(wr_addr) == 30, "R8 hold without enable", int'(wr_addr), 30);
    check(wr_en == 1'b0, "R8 strobe low", int'(wr_en), 0);
    smp_en = 1'b1;
    expect_done(127);
    tick(132 - elapsed);
    check(active == 1'b1 && int'(wr_addr) == 127, "R4 before limit", int'(wr_addr), 127);
    tick(1);
    check(active == 1'b0, "R4 closed at limit", int'(active), 0);
    check(done == 1'b1, "R10 done high", int'(done), 1);
    tick(1);
    check(done == 1'b0, "R10 done single", int'(done), 0);

    // stop with delay 5
    open_window(0);
    tick(10);
    cfg_stop_dly = DLY_W'(5);
    expect_done(17);
    pulse_stop();
    tick(6);
    check(active == 1'b1, "R3 early", int'(active), 1);
    tick(1);
    check(active == 1'b0, "R3 closed", int'(active), 0);
    tick(3);

    // stop while idle ignored
    cfg_stop_dly = DLY_W'(2);
    pulse_stop();
    tick(8);
    check(active == 1'b0, "R9 idle stop", int'(active), 0);

    // code 6 selects 256 samples
    cfg_size = 3'd6;
    open_window(1);
    expect_done(255);
    tick(255);
    check(active == 1'b1 && int'(wr_addr) == 255, "R5 256 page end", int'(wr_addr), 255);
    tick(1);
    check(active == 1'b0, "R5 256 closed", int'(active), 0);
    tick(3);

    // wrap in triggered mode
    cfg_size = 3'd7;
    cfg_wrap = 1'b1;
    open_window(0);
    tick(150);
    check(active == 1'b1 && int'(wr_addr) == 22, "R7 rolled", int'(wr_addr), 22);
    cfg_stop_dly = DLY_W'(1);
    expect_done(25);
    pulse_stop();
    tick(2);
    check(active == 1'b1, "R7 open before stop", int'(active), 1);
    tick(1);
    check(active == 1'b0, "R7 stop closes", int'(active), 0);
    cfg_wrap = 1'b0;
    tick(3);

    // reset discards a pending start
    cfg_start_dly = DLY_W'(10);
    pulse_start();
    tick(3);
    rst = 1'b1; tick(1); rst = 1'b0;
    tick(20);
    check(active == 1'b0, "R1 pending start cancelled", int'(active), 0);

    // continuous mode
    cfg_free_run = 1'b1;
    rst = 1'b1; tick(2); rst = 1'b0;
    tick(1);
    check(active == 1'b1, "R6 open after reset", int'(active), 1);
    elapsed = 0;
    tick(200);
    check(active == 1'b1 && int'(wr_addr) == 72, "R6 no size limit", int'(wr_addr), 72);
    cfg_stop_dly = DLY_W'(0);
    expect_done(74);
    pulse_stop();
    tick(1);
    check(active == 1'b1, "R6 before stop", int'(active), 1);
    tick(1);
    check(active == 1'b0, "R6 stop closes", int'(active), 0);
    tick(5);
    check(active == 1'b0, "R6 stays closed", int'(active), 0);
    open_window(0);

    tick(2);
    check(exp_q.size() == 0, "R10 all windows reported", exp_q.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule